// File: doc/BRIEF.md
# Periodic Sampling Configuration Selector

This block chooses, while the machine runs, which thread-to-cluster mapping the steering logic should use. A long epoch timer starts a short sampling phase at the beginning of every epoch. In that phase each candidate mapping is applied in ascending index order for a fixed trial window. A performance increment, for example the number of instructions committed in that cycle, is summed over each trial. The candidate with the largest sum wins the round.

Every round adds one vote to its winner. When the configured number of rounds has been collected, the candidate with the most votes becomes the active mapping. A tie in votes goes to the candidate that spreads each thread over more clusters. The vote counters are then cleared, and the chosen mapping stays in force until the next decision.

A parameter table gives each candidate's clusters-per-thread value. A system designer can leave out a mapping, such as the one that spreads every thread over all clusters, simply by not listing it. The index output follows the trial candidate while sampling is in progress and the active mapping at all other times. A flag marks the trial windows so that downstream logic can discount the transient effects of switching.

Top module: `cfg_sel_top`

## Requirements
- R1: While reset is high, `sampling_o` is 0 and `cfg_o` equals INIT_CFG (default 0). Reset clears all vote counts and the round count. The first sampling phase begins at the first clock edge after reset is released.
- R2: A sampling phase starts once every EPOCH_CYCLES cycles. It lasts exactly NUM_CAND*TRIAL_CYCLES cycles, and `sampling_o` is 1 for all of them. `sampling_o` is 0 for the other EPOCH_CYCLES-NUM_CAND*TRIAL_CYCLES cycles of the epoch.
- R3: During sampling, `cfg_o` takes the values 0, 1, ... NUM_CAND-1 in that order. Each value is held for TRIAL_CYCLES consecutive cycles.
- R4: A candidate's score is the sum of `perf_inc_i` over every cycle of its own trial window, including the first and last cycles.
- R5: Within one round, the candidate with the highest score wins. If scores are exactly equal, the lower index wins.
- R6: After ROUNDS rounds, the candidate that won the most rounds is applied. It appears on `cfg_o` in the first cycle after the last trial window.
- R7: If vote counts are equal, the candidate with the larger clusters-per-thread value wins. That value is the SPREAD_W-bit field at bits [i*SPREAD_W +: SPREAD_W] of CAND_SPREAD for candidate i. If both votes and spread are equal, the lower index wins.
- R8: Outside sampling, `cfg_o` holds the active mapping unchanged. A round that is not the final one of its group does not change the active mapping.
- R9: Vote counts and the round count are cleared after each decision. Each decision therefore depends only on its own ROUNDS rounds.
- R10: `perf_inc_i` has no effect on any score outside the trial windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perf_inc_i | input | INC_W | Performance increment for the current cycle |
| cfg_o | output | 4 | Mapping index: the trial candidate while sampling, otherwise the active mapping |
| sampling_o | output | 1 | High during trial windows |

## Verification
The bound checker checks several properties on every cycle:
- the reset state;
- that a sampling phase starts at candidate 0 and steps up by at most one index per cycle;
- the exact length of each sampling phase;
- that the index stays in range;
- that the mapping is stable across non-sampling cycles.

Some behaviours can only be shown by the bench's scenarios, because they depend on the values of the sums over time:
- which candidate wins a round, including the exact-tie rule;
- the majority vote and the spread tie-break;
- the clearing of votes between decisions;
- ignoring the increment outside trials;
- whole-window accumulation, which is tested with front-loaded and back-loaded increment patterns.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;

    localparam int CAND_IDX_W = 4;
    localparam int TALLY_W    = 8;
    localparam int SPREAD_MAX = 8;

    typedef logic [CAND_IDX_W-1:0] cand_idx_t;
    typedef logic [TALLY_W-1:0]    tally_t;
    typedef logic [SPREAD_MAX-1:0] spread_t;

    typedef enum logic {
        PH_RUN    = 1'b0,
        PH_SAMPLE = 1'b1
    } phase_e;

    typedef struct packed {
        logic      done;
        cand_idx_t winner;
    } round_res_t;

    typedef struct packed {
        phase_e    phase;
        logic      trial_last;
        logic      round_last;
        cand_idx_t cand;
    } seq_state_t;

    // True when candidate a must replace the current best b in the vote.
    function automatic logic vote_beats(tally_t cnt_a, spread_t spr_a,
                                        tally_t cnt_b, spread_t spr_b);
        return (cnt_a > cnt_b) || ((cnt_a == cnt_b) && (spr_a > spr_b));
    endfunction

endpackage

// File: rtl/cfg_epoch_seq.sv
module cfg_epoch_seq
    import cfg_sel_pkg::*;
#(
    parameter int EPOCH_CYCLES = 1000000,
    parameter int TRIAL_CYCLES = 1000,
    parameter int NUM_CAND     = 3
) (
    input  logic       clk,
    input  logic       rst,
    output seq_state_t st_o
);
    localparam int EP_W = $clog2(EPOCH_CYCLES + 1);
    localparam int TR_W = $clog2(TRIAL_CYCLES + 1);

    logic [EP_W-1:0] ep_q;
    logic [TR_W-1:0] tr_q;
    cand_idx_t       cand_q;
    phase_e          ph_q;

    logic ep_wrap, tr_end, cand_end;

    assign ep_wrap  = (ep_q == EP_W'(EPOCH_CYCLES - 1));
    assign tr_end   = (tr_q == TR_W'(TRIAL_CYCLES - 1));
    assign cand_end = (cand_q == cand_idx_t'(NUM_CAND - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_q   <= EP_W'(EPOCH_CYCLES - 1);
            tr_q   <= '0;
            cand_q <= '0;
            ph_q   <= PH_RUN;
        end else begin
            ep_q <= ep_wrap ? '0 : ep_q + 1'b1;
            unique case (ph_q)
                PH_RUN: begin
                    if (ep_wrap) begin
                        ph_q   <= PH_SAMPLE;
                        tr_q   <= '0;
                        cand_q <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (tr_end) begin
                        tr_q <= '0;
                        if (cand_end) begin
                            ph_q   <= PH_RUN;
                            cand_q <= '0;
                        end else begin
                            cand_q <= cand_q + 1'b1;
                        end
                    end else begin
                        tr_q <= tr_q + 1'b1;
                    end
                end
                default: ph_q <= PH_RUN;
            endcase
        end
    end

    always_comb begin
        st_o.phase      = ph_q;
        st_o.cand       = cand_q;
        st_o.trial_last = (ph_q == PH_SAMPLE) && tr_end;
        st_o.round_last = (ph_q == PH_SAMPLE) && tr_end && cand_end;
    end

endmodule

// File: rtl/cfg_round_judge.sv
module cfg_round_judge
    import cfg_sel_pkg::*;
#(
    parameter int INC_W        = 8,
    parameter int TRIAL_CYCLES = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_t       st_i,
    input  logic [INC_W-1:0] perf_inc_i,
    output round_res_t       res_o
);
    localparam int ACC_W = INC_W + $clog2(TRIAL_CYCLES + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] best_q;
    cand_idx_t        best_idx_q;
    logic [ACC_W-1:0] sum_now;
    logic             take;

    assign sum_now = acc_q + ACC_W'(perf_inc_i);
    // First candidate of a round always seeds the best; later ones need a strict win.
    assign take    = (st_i.cand == '0) || (sum_now > best_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            best_q     <= '0;
            best_idx_q <= '0;
        end else if (st_i.phase == PH_SAMPLE) begin
            if (st_i.trial_last) begin
                acc_q <= '0;
                if (take) begin
                    best_q     <= sum_now;
                    best_idx_q <= st_i.cand;
                end
            end else begin
                acc_q <= sum_now;
            end
        end
    end

    always_comb begin
        res_o.done   = st_i.round_last;
        res_o.winner = take ? st_i.cand : best_idx_q;
    end

endmodule

// File: rtl/cfg_vote_tally.sv
module cfg_vote_tally
    import cfg_sel_pkg::*;
#(
    parameter int                       NUM_CAND    = 3,
    parameter int                       ROUNDS      = 5,
    parameter int                       SPREAD_W    = 4,
    parameter logic [NUM_CAND*SPREAD_W-1:0] CAND_SPREAD = 12'h124,
    parameter int                       INIT_CFG    = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  round_res_t res_i,
    output cand_idx_t  active_o
);
    tally_t    tally_q  [NUM_CAND];
    tally_t    tally_nx [NUM_CAND];
    spread_t   spr      [NUM_CAND];
    tally_t    rnd_q;
    cand_idx_t active_q;
    cand_idx_t pick;
    logic      final_rnd;

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
        assign spr[g]      = spread_t'(CAND_SPREAD[g*SPREAD_W +: SPREAD_W]);
        assign tally_nx[g] = tally_q[g] +
                             tally_t'(res_i.done && (res_i.winner == cand_idx_t'(g)));
    end

    assign final_rnd = res_i.done && (rnd_q == tally_t'(ROUNDS - 1));

    always_comb begin
        tally_t  bc;
        spread_t bs;
        pick = '0;
        bc   = tally_nx[0];
        bs   = spr[0];
        for (int i = 1; i < NUM_CAND; i++) begin
            if (vote_beats(tally_nx[i], spr[i], bc, bs)) begin
                pick = cand_idx_t'(i);
                bc   = tally_nx[i];
                bs   = spr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CAND; i++) tally_q[i] <= '0;
            rnd_q    <= '0;
            active_q <= cand_idx_t'(INIT_CFG);
        end else if (final_rnd) begin
            for (int i = 0; i < NUM_CAND; i++) tally_q[i] <= '0;
            rnd_q    <= '0;
            active_q <= pick;
        end else if (res_i.done) begin
            for (int i = 0; i < NUM_CAND; i++) tally_q[i] <= tally_nx[i];
            rnd_q    <= rnd_q + 1'b1;
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/cfg_sel_top.sv
module cfg_sel_top
    import cfg_sel_pkg::*;
#(
    parameter int                       EPOCH_CYCLES = 1000000,
    parameter int                       TRIAL_CYCLES = 1000,
    parameter int                       ROUNDS       = 5,
    parameter int                       NUM_CAND     = 3,
    parameter int                       INC_W        = 8,
    parameter int                       SPREAD_W     = 4,
    parameter logic [NUM_CAND*SPREAD_W-1:0] CAND_SPREAD = 12'h124,
    parameter int                       INIT_CFG     = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [INC_W-1:0]      perf_inc_i,
    output logic [CAND_IDX_W-1:0] cfg_o,
    output logic                  sampling_o
);
    seq_state_t st;
    round_res_t res;
    cand_idx_t  active;

    cfg_epoch_seq #(
        .EPOCH_CYCLES(EPOCH_CYCLES),
        .TRIAL_CYCLES(TRIAL_CYCLES),
        .NUM_CAND    (NUM_CAND)
    ) u_seq (
        .clk (clk),
        .rst (rst),
        .st_o(st)
    );

    cfg_round_judge #(
        .INC_W       (INC_W),
        .TRIAL_CYCLES(TRIAL_CYCLES)
    ) u_judge (
        .clk       (clk),
        .rst       (rst),
        .st_i      (st),
        .perf_inc_i(perf_inc_i),
        .res_o     (res)
    );

    cfg_vote_tally #(
        .NUM_CAND   (NUM_CAND),
        .ROUNDS     (ROUNDS),
        .SPREAD_W   (SPREAD_W),
        .CAND_SPREAD(CAND_SPREAD),
        .INIT_CFG   (INIT_CFG)
    ) u_vote (
        .clk     (clk),
        .rst     (rst),
        .res_i   (res),
        .active_o(active)
    );

    assign sampling_o = (st.phase == PH_SAMPLE);
    assign cfg_o      = sampling_o ? st.cand : active;

endmodule

// File: rtl/cfg_sel_chk.sv
module cfg_sel_chk
    import cfg_sel_pkg::*;
#(
    parameter int NUM_CAND     = 3,
    parameter int TRIAL_CYCLES = 1000,
    parameter int INIT_CFG     = 0
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CAND_IDX_W-1:0] cfg_o,
    input logic                  sampling_o
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= 0;
        else if (sampling_o) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    // R1
    a_r1_idle_in_reset: assert property (@(posedge clk)
        rst |=> (!sampling_o && cfg_o == CAND_IDX_W'(INIT_CFG)));

    // R3
    a_r3_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(sampling_o) |-> cfg_o == '0);

    // R3
    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (sampling_o && $past(sampling_o)) |->
            (cfg_o == $past(cfg_o) || cfg_o == $past(cfg_o) + 1'b1));

    // R2
    a_r2_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(sampling_o) |-> run_len == NUM_CAND * TRIAL_CYCLES);

    // R3
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        cfg_o < CAND_IDX_W'(NUM_CAND));

    // R8
    a_r8_hold_outside: assert property (@(posedge clk) disable iff (rst)
        (!sampling_o && !$past(sampling_o)) |-> $stable(cfg_o));

endmodule

bind cfg_sel_top cfg_sel_chk #(
    .NUM_CAND    (NUM_CAND),
    .TRIAL_CYCLES(TRIAL_CYCLES),
    .INIT_CFG    (INIT_CFG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_o     (cfg_o),
    .sampling_o(sampling_o)
);

// File: tb/sim_cfg_sel_top.sv
module sim_cfg_sel_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC    = 3;
    localparam int TRIAL = 8;
    localparam int EPOCH = 40;
    localparam int RNDS  = 5;
    localparam int SL    = NC * TRIAL;
    localparam int WD    = 20000;

    // Scenario: [63:60] expected choice; round r at [r*12 +: 12];
    // candidate c per-cycle rate at [c*4 +: 4] inside a round.
    localparam logic [63:0] SCN [6] = '{
        64'h1_253_253_253_253_253,   // c1 wins every round
        64'h2_291_713_713_126_126,   // c0:2 c2:2 c1:1 -> spread picks c2
        64'h0_444_444_444_444_444,   // equal scores -> c0 each round
        64'h1_713_126_126_291_291,   // c1:2 c0:2 c2:1 -> spread picks c1
        64'h1_661_713_661_713_661,   // equal c1/c2 scores -> c1; majority c1
        64'h0_126_713_126_713_126    // c0:3 beats c2:2 despite spread
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] perf = 4'hF;
    logic [3:0] cfg_o;
    logic       sampling_o;

    logic [3:0] cur_rate [NC];
    bit         burst = 1'b0;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         prev_active = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_sel_top #(
        .EPOCH_CYCLES(EPOCH),
        .TRIAL_CYCLES(TRIAL),
        .ROUNDS      (RNDS),
        .NUM_CAND    (NC),
        .INC_W       (4),
        .SPREAD_W    (4),
        .CAND_SPREAD (12'h421),
        .INIT_CFG    (0)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .perf_inc_i(perf),
        .cfg_o     (cfg_o),
        .sampling_o(sampling_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] perf_for(input int c, input int off);
        if (burst) begin
            if (c == 0) return (off == 0) ? 4'd15 : 4'd0;
            if (c == 1) return 4'd3;
            return (off == TRIAL - 1) ? 4'd10 : 4'd0;
        end
        return cur_rate[c];
    endfunction

    task automatic load_round(input logic [11:0] r);
        for (int c = 0; c < NC; c++) cur_rate[c] = r[c*4 +: 4];
    endtask

    // Runs one sampling phase; returns idle cycles seen before it began.
    task automatic run_round(output int idle_n);
        int k;
        bit seen;
        k = 0; seen = 0; idle_n = 0;
        forever begin
            @(negedge clk);
            if (sampling_o) begin
                seen = 1;
                check(int'(cfg_o) == k / TRIAL, "R3 trial index", int'(cfg_o), k / TRIAL);
                perf = perf_for(int'(cfg_o), k % TRIAL);
                k++;
            end else begin
                perf = 4'hF;   // noise outside windows (R10)
                if (seen) break;
                idle_n++;
            end
        end
        check(k == SL, "R2 window length", k, SL);
    endtask

    task automatic run_group(input logic [63:0] s, input bit after_reset);
        int idle;
        int exp_c;
        exp_c = int'(s[63:60]);
        for (int r = 0; r < RNDS; r++) begin
            load_round(s[r*12 +: 12]);
            run_round(idle);
            if (r == 0 && after_reset)
                check(idle == 0, "R1 first phase start", idle, 0);
            else
                check(idle == EPOCH - SL - 1, "R2 epoch spacing", idle, EPOCH - SL - 1);
            if (r < RNDS - 1)
                check(int'(cfg_o) == prev_active, "R8 hold between decisions",
                      int'(cfg_o), prev_active);
            else
                check(int'(cfg_o) == exp_c, "R6 R7 R5 R9 decision", int'(cfg_o), exp_c);
        end
        prev_active = exp_c;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sampling_o == 1'b0, "R1 sampling in reset", int'(sampling_o), 0);
        check(cfg_o == 4'd0, "R1 cfg in reset", int'(cfg_o), 0);
        load_round(SCN[0][11:0]);
        rst = 1'b0;

        // Table walk: R5 R6 R7 R8 R9 R10
        for (int s = 0; s < 6; s++) run_group(SCN[s], s == 0);

        // R4: whole-window sum (front-loaded 15, flat 24, back-loaded 10) -> c1
        burst = 1'b1;
        run_group({4'h1, 60'h0}, 1'b0);
        burst = 1'b0;

        // R1 R9: reset in mid-phase after three c2 wins discards them
        begin
            int idle;
            for (int r = 0; r < 3; r++) begin
                load_round(12'h713);
                run_round(idle);
            end
            @(negedge clk);
            while (!sampling_o) @(negedge clk);
            repeat (5) @(negedge clk);
            rst = 1'b1;
            perf = 4'hF;
            repeat (2) @(negedge clk);
            check(sampling_o == 1'b0, "R1 sampling after mid reset", int'(sampling_o), 0);
            check(cfg_o == 4'd0, "R1 cfg after mid reset", int'(cfg_o), 0);
            prev_active = 0;
            load_round(12'h126);
            rst = 1'b0;
            run_group(64'h1_713_291_291_126_126, 1'b1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule